// File: doc/BRIEF.md
# Power Mode and Indicator Control Register

This block is a 16-bit read/write control word on a host register bus of a network controller. It decides the controller's low-power state and the source of two indicator output pins. A host write can request a chip-wide reset, which is issued as a one-cycle pulse. A host write can also place the controller in a software-held suspend, which only a later host bus write can end. Through a control bit, the host can let an external wake input choose between awake and a hardware low-power state. That hardware state is either standby or suspend, as another bit selects.

Each of the two indicator pins is routed either from an internal status signal or from a host-owned bit, and the host-owned level is active low. A boot-time load port stands in for a non-volatile configuration loader. It supplies an initial register value, and every later chip reset returns the register to that value.

Top module: `pmIndCtl`

## Requirements
- R1: After reset, the word reads 0x0015, the mode output is 00 (awake), chipRstPulse, partRst and trxBlock are low, and each indicator pin follows its status input.
- R2: A read of address 0x114 returns 010101b in bits 5:0. Bits 6, 7 and 11 read 0. The writable bits are 8, 9, 10, 12, 13, 14 and 15.
- R3: A write to 0x114 with bit 6 set raises chipRstPulse for exactly the one cycle after the write. That pulse returns the word to its boot value. A write with bit 6 clear raises no pulse.
- R4: When bit 8 is 1, the mode output is 11 (software suspend) and both partRst and trxBlock are high. In every other mode both are low.
- R5: A host write to any address other than 0x114 clears bit 8. A write to 0x114 loads bit 8 from the write data.
- R6: When bit 9 is 0, the wake input has no effect on the mode.
- R7: When bit 9 is 1, the wake input is sampled through SYNC_STAGES flops. Wake low gives mode 01 (standby) if bit 10 is 1 and mode 10 (suspend) if bit 10 is 0. Wake high gives 00.
- R8: Software suspend (11) takes priority over any mode chosen by the wake input.
- R9: When bit 12 is 0, indOut[0] equals indStatus[0] and bit 14 is ignored. When bit 12 is 1, indOut[0] is low if bit 14 is 1 and high if bit 14 is 0.
- R10: When bit 13 is 0, indOut[1] equals indStatus[1] and bit 15 is ignored. When bit 13 is 1, indOut[1] is low if bit 15 is 1 and high if bit 15 is 0.
- R11: A cycle with bootLoadVld high loads the writable bits of bootLoadData into the word. They also become the value that a later chip reset restores.
- R12: A write to another address leaves every bit of the word other than bit 8 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Host register address |
| busWrEn | input | 1 | Host write strobe |
| busWrData | input | 16 | Host write data |
| busRdData | output | 16 | Read data, the word when the address hits 0x114, otherwise 0 |
| bootLoadVld | input | 1 | Boot-time load strobe |
| bootLoadData | input | 16 | Boot-time load value |
| wakeIn | input | 1 | External wake level (high = awake), asynchronous |
| indStatus | input | 2 | Internal status sources for the indicator pins |
| indOut | output | 2 | Indicator pin levels |
| pwrMode | output | 2 | Power mode: 00 awake, 01 standby, 10 suspend, 11 software suspend |
| partRst | output | 1 | Partial reset for the rest of the controller |
| trxBlock | output | 1 | Blocks transmit and receive |
| chipRstPulse | output | 1 | One-cycle chip reset pulse |

## Verification
The assertions assume that the bus address and write strobe are stable within a cycle. They also assume that the boot load strobe and a host write never arrive in the same cycle as a chip reset pulse, since the priority among them is fixed and not re-derived by the properties. The directed stimulus changes inputs only at the falling clock edge and leaves idle cycles between a reset request and the next access. It also holds the wake input steady for longer than the synchronizer depth before it checks the mode.

// File: rtl/pmIndPkg.sv
package pmIndPkg;
  localparam int WORD_W   = 16;
  localparam int ID_W     = 6;
  localparam int RST_BIT  = 6;
  localparam int SUSP_BIT = 8;
  localparam int SLPEN_BIT = 9;
  localparam int STBY_BIT = 10;
  localparam int OWN_BASE = 12;
  localparam int LVL_BASE = 14;
  localparam int NUM_IND  = 2;
  localparam logic [ID_W-1:0]   ID_VAL  = 6'b010101;
  localparam logic [WORD_W-1:0] WR_MASK = 16'hF700;

  typedef enum logic [1:0] {
    PM_AWAKE    = 2'b00,
    PM_STANDBY  = 2'b01,
    PM_HWSUSP   = 2'b10,
    PM_SWSUSP   = 2'b11
  } pwrMode_e;

  typedef struct packed {
    logic rdHit;
    logic wrHit;
    logic wrMiss;
    logic rstFire;
    logic bootLoad;
  } strobes_t;
endpackage

// File: rtl/pmIndCtrl.sv
module pmIndCtrl
  import pmIndPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h114,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              rstReqBit,
  input  logic              bootLoadVld,
  input  logic              wakeIn,
  output strobes_t          strobes,
  output logic              wakeSync,
  output logic              chipRstPulse
);
  logic addrHit;
  logic rstPend;

  assign addrHit = (busAddr == REG_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rstPend <= 1'b0;
    else       rstPend <= busWrEn && addrHit && rstReqBit && !rstPend;
  end
  assign chipRstPulse = rstPend;

  always_comb begin
    strobes.rdHit    = addrHit;
    strobes.rstFire  = rstPend;
    strobes.bootLoad = bootLoadVld && !rstPend;
    strobes.wrHit    = busWrEn && addrHit && !rstPend && !bootLoadVld;
    strobes.wrMiss   = busWrEn && !addrHit && !rstPend && !bootLoadVld;
  end

  generate
    if (SYNC_STAGES == 0) begin : gNoSync
      assign wakeSync = wakeIn;
    end else begin : gSync
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], wakeIn};
      end
      assign wakeSync = syncChain[SYNC_STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/pmIndDatapath.sv
module pmIndDatapath
  import pmIndPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobes_t            strobes,
  input  logic [WORD_W-1:0]   busWrData,
  input  logic [WORD_W-1:0]   bootLoadData,
  input  logic                wakeSync,
  input  logic [NUM_IND-1:0]  indStatus,
  output logic [WORD_W-1:0]   rdWord,
  output logic [1:0]          pwrMode,
  output logic                partRst,
  output logic                trxBlock,
  output logic [NUM_IND-1:0]  indOut
);
  logic [WORD_W-1:0] ctlWord;
  logic [WORD_W-1:0] bootWord;
  pwrMode_e          modeNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bootWord <= '0;
    else if (strobes.bootLoad) bootWord <= bootLoadData & WR_MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlWord <= '0;
    end else if (strobes.rstFire) begin
      ctlWord <= bootWord;
    end else if (strobes.bootLoad) begin
      ctlWord <= bootLoadData & WR_MASK;
    end else if (strobes.wrHit) begin
      ctlWord <= busWrData & WR_MASK;
    end else if (strobes.wrMiss) begin
      ctlWord[SUSP_BIT] <= 1'b0;
    end
  end

  assign rdWord = strobes.rdHit ? (ctlWord | {{(WORD_W-ID_W){1'b0}}, ID_VAL}) : '0;

  always_comb begin
    if (ctlWord[SUSP_BIT])
      modeNow = PM_SWSUSP;
    else if (ctlWord[SLPEN_BIT] && !wakeSync)
      modeNow = ctlWord[STBY_BIT] ? PM_STANDBY : PM_HWSUSP;
    else
      modeNow = PM_AWAKE;
  end

  assign pwrMode  = modeNow;
  assign partRst  = (modeNow == PM_SWSUSP);
  assign trxBlock = (modeNow == PM_SWSUSP);

  generate
    for (genvar i = 0; i < NUM_IND; i++) begin : gInd
      assign indOut[i] = ctlWord[OWN_BASE+i] ? !ctlWord[LVL_BASE+i] : indStatus[i];
    end
  endgenerate
endmodule

// File: rtl/pmIndCtl.sv
module pmIndCtl
  import pmIndPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h114,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [15:0]       busWrData,
  output logic [15:0]       busRdData,
  input  logic              bootLoadVld,
  input  logic [15:0]       bootLoadData,
  input  logic              wakeIn,
  input  logic [1:0]        indStatus,
  output logic [1:0]        indOut,
  output logic [1:0]        pwrMode,
  output logic              partRst,
  output logic              trxBlock,
  output logic              chipRstPulse
);
  strobes_t strobes;
  logic     wakeSync;

  pmIndCtrl #(
    .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .rstReqBit(busWrData[RST_BIT]), .bootLoadVld(bootLoadVld),
    .wakeIn(wakeIn), .strobes(strobes), .wakeSync(wakeSync),
    .chipRstPulse(chipRstPulse)
  );

  pmIndDatapath uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWrData(busWrData),
    .bootLoadData(bootLoadData), .wakeSync(wakeSync), .indStatus(indStatus),
    .rdWord(busRdData), .pwrMode(pwrMode), .partRst(partRst),
    .trxBlock(trxBlock), .indOut(indOut)
  );
endmodule

// File: rtl/pmIndCtlChk.sv
module pmIndCtlChk #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h114
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [15:0]       busWrData,
  input logic [15:0]       busRdData,
  input logic              bootLoadVld,
  input logic [1:0]        indOut,
  input logic [1:0]        pwrMode,
  input logic              partRst,
  input logic              trxBlock,
  input logic              chipRstPulse
);
  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    chipRstPulse |=> !chipRstPulse); // R3
  AST_RST_AFTER_WR: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == REG_ADDR && busWrData[6] && !chipRstPulse) |=> chipRstPulse); // R3
  AST_NO_RST_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == REG_ADDR && busWrData[6]) |=> !chipRstPulse); // R3
  AST_ID_FIELD: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == REG_ADDR) |-> (busRdData[5:0] == 6'b010101 && busRdData[7:6] == 2'b00
                               && !busRdData[11])); // R2
  AST_SUSP_OUTPUTS: assert property (@(posedge clk) disable iff (!rstN)
    (pwrMode == 2'b11) == (partRst && trxBlock)); // R4
  AST_SUSP_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr != REG_ADDR && !chipRstPulse && !bootLoadVld) |=> pwrMode != 2'b11); // R5
  AST_SUSP_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == REG_ADDR && busRdData[8]) |-> pwrMode == 2'b11); // R8
  AST_PIN0_HOST: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == REG_ADDR && busRdData[12]) |-> indOut[0] == !busRdData[14]); // R9
  AST_PIN1_HOST: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == REG_ADDR && busRdData[13]) |-> indOut[1] == !busRdData[15]); // R10
endmodule

bind pmIndCtl pmIndCtlChk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .bootLoadVld(bootLoadVld),
  .indOut(indOut), .pwrMode(pwrMode), .partRst(partRst), .trxBlock(trxBlock),
  .chipRstPulse(chipRstPulse)
);

// File: tb/sim_pmIndCtl.sv
`timescale 1ns/1ps
module sim_pmIndCtl;
  localparam logic [11:0] REG_A = 12'h114;
  localparam logic [11:0] OTHER_A = 12'h020;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = REG_A;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        bootLoadVld = 1'b0;
  logic [15:0] bootLoadData = '0;
  logic        wakeIn = 1'b1;
  logic [1:0]  indStatus = 2'b10;
  logic [1:0]  indOut;
  logic [1:0]  pwrMode;
  logic        partRst, trxBlock, chipRstPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pmIndCtl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .bootLoadVld(bootLoadVld),
    .bootLoadData(bootLoadData), .wakeIn(wakeIn), .indStatus(indStatus),
    .indOut(indOut), .pwrMode(pwrMode), .partRst(partRst), .trxBlock(trxBlock),
    .chipRstPulse(chipRstPulse)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = REG_A; busWrData = '0;
    #1;
  endtask

  task automatic testReset();
    check("R1 word", busRdData, 16'h0015);
    check("R1 mode", {14'd0, pwrMode}, 16'd0);
    check("R1 pulse/partRst/trx", {13'd0, chipRstPulse, partRst, trxBlock}, 16'd0);
    check("R1 pins", {14'd0, indOut}, {14'd0, indStatus});
  endtask

  task automatic testPins();
    wr(REG_A, 16'h5000);
    check("R9 host low", {15'd0, indOut[0]}, 16'd0);
    indStatus[0] = 1'b1; #1;
    check("R9 status ignored", {15'd0, indOut[0]}, 16'd0);
    wr(REG_A, 16'h1000);
    check("R9 host high", {15'd0, indOut[0]}, 16'd1);
    wr(REG_A, 16'h4000);
    indStatus[0] = 1'b0; #1;
    check("R9 level ignored, follows status", {15'd0, indOut[0]}, 16'd0);
    wr(REG_A, 16'hA000);
    check("R10 host low", {15'd0, indOut[1]}, 16'd0);
    wr(REG_A, 16'h2000);
    check("R10 host high", {15'd0, indOut[1]}, 16'd1);
    wr(REG_A, 16'h8000);
    indStatus[1] = 1'b0; #1;
    check("R10 level ignored, follows status", {15'd0, indOut[1]}, 16'd0);
    indStatus[1] = 1'b1; #1;
    check("R10 follows status high", {15'd0, indOut[1]}, 16'd1);
  endtask

  task automatic testSleep();
    wr(REG_A, 16'h0000);
    wakeIn = 1'b0; idle(4);
    check("R6 wake ignored", {14'd0, pwrMode}, 16'd0);
    wr(REG_A, 16'h0600); idle(1);
    check("R7 standby", {14'd0, pwrMode}, 16'd1);
    check("R4 no partRst in standby", {15'd0, partRst}, 16'd0);
    wr(REG_A, 16'h0200); idle(1);
    check("R7 hw suspend", {14'd0, pwrMode}, 16'd2);
    wakeIn = 1'b1; idle(4);
    check("R7 awake", {14'd0, pwrMode}, 16'd0);
  endtask

  task automatic testSwSuspend();
    wr(REG_A, 16'h0100);
    check("R4 mode", {14'd0, pwrMode}, 16'd3);
    check("R4 partRst/trx", {14'd0, partRst, trxBlock}, 16'd3);
    wakeIn = 1'b0;
    wr(REG_A, 16'h0700); idle(4);
    check("R8 priority", {14'd0, pwrMode}, 16'd3);
    wr(OTHER_A, 16'hFFFF);
    check("R5 exit by other write", {14'd0, pwrMode}, 16'd1);
    check("R12 other bits kept", busRdData, 16'h0615);
    wr(REG_A, 16'h0700);
    wr(REG_A, 16'h0600);
    check("R5 cleared by own write", {14'd0, pwrMode}, 16'd1);
    wakeIn = 1'b1; idle(4);
  endtask

  task automatic testChipReset();
    wr(REG_A, 16'h3300);
    check("R3 no pulse without bit", {15'd0, chipRstPulse}, 16'd0);
    wr(REG_A, 16'hF740);
    check("R3 pulse", {15'd0, chipRstPulse}, 16'd1);
    idle(1);
    check("R3 single cycle", {15'd0, chipRstPulse}, 16'd0);
    check("R3 boot value", busRdData, 16'h0015);
  endtask

  task automatic testBootLoad();
    @(negedge clk);
    bootLoadVld = 1'b1; bootLoadData = 16'hFFFF;
    @(negedge clk);
    bootLoadVld = 1'b0; bootLoadData = '0; #1;
    check("R11 loaded", busRdData, 16'hF715);
    wr(REG_A, 16'h0000);
    check("R2 writable cleared", busRdData, 16'h0015);
    wr(REG_A, 16'hFFBF);
    check("R2 reserved read zero", busRdData, 16'hF715);
    wr(REG_A, 16'h0040); idle(1);
    check("R11 reset restores load", busRdData, 16'hF715);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    testReset();
    testPins();
    testSleep();
    testSwSuspend();
    testChipReset();
    testBootLoad();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule